// File: doc/BRIEF.md
# Packed Low-Precision Multiplier Array

This block produces four independent signed 4-bit by 4-bit products per clock while using only one wide signed multiplier. Two operands of the first set are placed in a 27-bit word at bit offsets 0 and 22, and the two operands of the second set are placed in an 18-bit word at bit offsets 0 and 11. Because of these offsets, the single wide product carries the four small products side by side, at bits 0, 11, 22 and 33. Each small product is 8 bits wide and has 3 guard bits between it and the next one.

Taking a field straight out of the wide product rounds it toward minus infinity. So whenever the part of the product below a field is negative, that field reads one too low. A correction stage removes this borrow. It tests the guard bits just below each field and adds one when they show a negative lower part, which makes every product exact.

The block has a fixed two-stage pipeline. A new operand set can enter on every cycle, and each set is marked with a valid strobe. The outputs keep their last value when no valid set emerges from the pipeline.

Top module: `pmul_array`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly two clock cycles, and back-to-back valid inputs produce back-to-back valid outputs.
- R2: When `out_vld` is 1, `p00` equals the signed product `a0*b0` of the operands applied two cycles earlier. This is the lane at bit 0 of the wide product.
- R3: When `out_vld` is 1, `p01` equals `a0*b1`. This is the lane at bit 11, and it is corrected when the lane at bit 0 is negative.
- R4: When `out_vld` is 1, `p10` equals `a1*b0`. This is the lane at bit 22. It is corrected whenever everything below it is negative, including the case where `a0*b1` is 0 and `a0*b0` is negative.
- R5: When `out_vld` is 1, `p11` equals `a1*b1`. This is the lane at bit 33.
- R6: The extreme products are exact in every lane. These are -8*-8 = +64 and -8*7 = 7*-8 = -56.
- R7: While `out_vld` is 0, all four product outputs keep their previous values. Operand values presented with `in_vld` = 0 never reach the outputs.
- R8: A synchronous active-high `rst` clears `out_vld` and all four product outputs to 0 on the next clock edge. It also drops any operand sets still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks a valid operand set on `a0`, `a1`, `b0`, `b1` |
| a0 | input | 4 | Signed operand, first set, offset 0 in the 27-bit word |
| a1 | input | 4 | Signed operand, first set, offset 22 in the 27-bit word |
| b0 | input | 4 | Signed operand, second set, offset 0 in the 18-bit word |
| b1 | input | 4 | Signed operand, second set, offset 11 in the 18-bit word |
| out_vld | output | 1 | Marks valid products, two cycles after `in_vld` |
| p00 | output | 8 | Signed product a0*b0 |
| p01 | output | 8 | Signed product a0*b1 |
| p10 | output | 8 | Signed product a1*b0 |
| p11 | output | 8 | Signed product a1*b1 |

## Verification
On every cycle, the assertions check:
- the two-cycle valid delay;
- the exactness of each lane against the operands seen two cycles earlier;
- that the outputs hold while no result is valid;
- the reset clearing;
- that the guard bits below each upper lane of the stored wide product are all copies of one sign.

The assertions cannot show that the correction is right for every operand combination, because they only judge the values the stimulus happens to reach. The bench drives all 65,536 operand combinations through its reference model, with idle gaps in between and a reset in mid-stream. It also drives directed extremes and the case where a zero product sits above a negative one. These show that no borrow pattern is ever mishandled.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    // Number of small products formed from one wide multiply (2 x 2 operands).
    localparam int LANES = 4;

    // Bit offset of lane k inside the wide product, given the lane stride.
    function automatic int lane_offset(input int k, input int stride);
        return k * stride;
    endfunction

    // Operand of the first set feeding lane k (lanes are ordered a0b0, a0b1, a1b0, a1b1).
    function automatic int lane_a_sel(input int k);
        return k / 2;
    endfunction

    // Operand of the second set feeding lane k.
    function automatic int lane_b_sel(input int k);
        return k % 2;
    endfunction

endpackage

// File: rtl/pmul_pack.sv
module pmul_pack #(
    parameter int OP_W   = 4,
    parameter int STRIDE = 11,
    parameter int A_W    = 27,
    parameter int B_W    = 18
) (
    input  logic signed [OP_W-1:0] a0,
    input  logic signed [OP_W-1:0] a1,
    input  logic signed [OP_W-1:0] b0,
    input  logic signed [OP_W-1:0] b1,
    output logic signed [A_W-1:0]  word_a,
    output logic signed [B_W-1:0]  word_b
);

    // The high operand of the first set sits two strides up,
    // and the high operand of the second set sits one stride up.
    localparam int A_HI_OFF = 2 * STRIDE;
    localparam int B_HI_OFF = STRIDE;

    logic signed [A_W-1:0] a_lo_ext, a_hi_ext;
    logic signed [B_W-1:0] b_lo_ext, b_hi_ext;

    always_comb begin
        // Each operand is sign-extended to the full word width before it is shifted.
        a_lo_ext = A_W'(a0);
        a_hi_ext = A_W'(a1) <<< A_HI_OFF;
        b_lo_ext = B_W'(b0);
        b_hi_ext = B_W'(b1) <<< B_HI_OFF;

        // The sum, not a concatenation, folds the low operand's sign into the word.
        word_a = a_lo_ext + a_hi_ext;
        word_b = b_lo_ext + b_hi_ext;
    end

endmodule

// File: rtl/pmul_wide.sv
module pmul_wide #(
    parameter int A_W   = 27,
    parameter int B_W   = 18,
    parameter int USE_W = 41
) (
    input  logic signed [A_W-1:0]   word_a,
    input  logic signed [B_W-1:0]   word_b,
    output logic        [USE_W-1:0] prod
);

    // Only the low USE_W bits carry lanes.
    // A product taken modulo 2^USE_W is exact in those bits.
    logic signed [USE_W-1:0] a_ext, b_ext;

    always_comb begin
        a_ext = USE_W'(word_a);
        b_ext = USE_W'(word_b);
        prod  = a_ext * b_ext;
    end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
    parameter int PROD_W = 8,
    parameter int GUARD  = 3
) (
    input  logic [PROD_W-1:0] field,
    input  logic [GUARD-1:0]  guard_below,
    output logic [PROD_W-1:0] result
);

    // Below a field, the guard bits are all copies of the sign of the lower part.
    // A negative lower part means the field was floored one too low,
    // so one is added back.
    logic borrow;

    always_comb begin
        borrow = |guard_below;
        result = field + {{(PROD_W-1){1'b0}}, borrow};
    end

endmodule

// File: rtl/pmul_array.sv
module pmul_array #(
    parameter int OP_W  = 4,
    parameter int GUARD = 3,
    parameter int A_W   = 27,
    parameter int B_W   = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [OP_W-1:0]   a0,
    input  logic signed [OP_W-1:0]   a1,
    input  logic signed [OP_W-1:0]   b0,
    input  logic signed [OP_W-1:0]   b1,
    output logic                     out_vld,
    output logic signed [2*OP_W-1:0] p00,
    output logic signed [2*OP_W-1:0] p01,
    output logic signed [2*OP_W-1:0] p10,
    output logic signed [2*OP_W-1:0] p11
);

    import pmul_pkg::*;

    localparam int PROD_W = 2 * OP_W;
    localparam int STRIDE = PROD_W + GUARD;
    localparam int USE_W  = (LANES - 1) * STRIDE + PROD_W;

    logic signed [A_W-1:0] word_a;
    logic signed [B_W-1:0] word_b;
    logic [USE_W-1:0]      prod_w;

    // Stage 1 state: the stored wide product.
    logic                  vld_s1;
    logic [USE_W-1:0]      prod_s1;

    // Stage 2 state: the corrected lanes.
    logic [LANES-1:0][PROD_W-1:0] lane_res;
    logic [LANES-1:0][PROD_W-1:0] res_q;

    pmul_pack #(
        .OP_W  (OP_W),
        .STRIDE(STRIDE),
        .A_W   (A_W),
        .B_W   (B_W)
    ) u_pack (
        .a0    (a0),
        .a1    (a1),
        .b0    (b0),
        .b1    (b1),
        .word_a(word_a),
        .word_b(word_b)
    );

    pmul_wide #(
        .A_W  (A_W),
        .B_W  (B_W),
        .USE_W(USE_W)
    ) u_wide (
        .word_a(word_a),
        .word_b(word_b),
        .prod  (prod_w)
    );

    // Stage 1: register the wide product, loading it only for a valid set.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_s1  <= 1'b0;
            prod_s1 <= '0;
        end else begin
            vld_s1 <= in_vld;
            if (in_vld) begin
                prod_s1 <= prod_w;
            end
        end
    end

    // One extraction-and-correction lane per small product.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int OFF = lane_offset(k, STRIDE);
        logic [GUARD-1:0] guard_k;

        if (k == 0) begin : g_bottom
            assign guard_k = '0;
        end else begin : g_upper
            assign guard_k = prod_s1[OFF-1 -: GUARD];
        end

        pmul_lane #(
            .PROD_W(PROD_W),
            .GUARD (GUARD)
        ) u_lane (
            .field      (prod_s1[OFF +: PROD_W]),
            .guard_below(guard_k),
            .result     (lane_res[k])
        );
    end

    // Stage 2: register the corrected products, holding them while idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            res_q   <= '0;
        end else begin
            out_vld <= vld_s1;
            if (vld_s1) begin
                res_q <= lane_res;
            end
        end
    end

    assign p00 = res_q[0];
    assign p01 = res_q[1];
    assign p10 = res_q[2];
    assign p11 = res_q[3];

endmodule

// File: rtl/pmul_array_chk.sv
module pmul_array_chk #(
    parameter int OP_W  = 4,
    parameter int GUARD = 3,
    parameter int USE_W = 41
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_vld,
    input logic signed [OP_W-1:0]   a0,
    input logic signed [OP_W-1:0]   a1,
    input logic signed [OP_W-1:0]   b0,
    input logic signed [OP_W-1:0]   b1,
    input logic                     out_vld,
    input logic signed [2*OP_W-1:0] p00,
    input logic signed [2*OP_W-1:0] p01,
    input logic signed [2*OP_W-1:0] p10,
    input logic signed [2*OP_W-1:0] p11,
    input logic [USE_W-1:0]         prod_s1
);

    localparam int PROD_W = 2 * OP_W;
    localparam int STRIDE = PROD_W + GUARD;

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> ##1 out_vld); // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ##1 !out_vld); // R1

    AST_LANE_A0B0: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> p00 == PROD_W'($past(a0, 2)) * PROD_W'($past(b0, 2))); // R2
    AST_LANE_A0B1: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> p01 == PROD_W'($past(a0, 2)) * PROD_W'($past(b1, 2))); // R3
    AST_LANE_A1B0: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> p10 == PROD_W'($past(a1, 2)) * PROD_W'($past(b0, 2))); // R4
    AST_LANE_A1B1: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> p11 == PROD_W'($past(a1, 2)) * PROD_W'($past(b1, 2))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!out_vld && !$past(rst)) |-> ($stable(p00) && $stable(p01) && $stable(p10) && $stable(p11))); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_vld && p00 == '0 && p01 == '0 && p10 == '0 && p11 == '0)); // R8

    for (genvar k = 1; k < 4; k++) begin : g_guard
        localparam int OFF = k * STRIDE;
        AST_GUARD_CLEAN: assert property (@(posedge clk) disable iff (rst)
            ($countones(prod_s1[OFF-1 -: GUARD]) == 0) || ($countones(prod_s1[OFF-1 -: GUARD]) == GUARD)); // R4
    end

endmodule

bind pmul_array pmul_array_chk #(
    .OP_W (OP_W),
    .GUARD(GUARD),
    .USE_W(USE_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_vld (in_vld),
    .a0     (a0),
    .a1     (a1),
    .b0     (b0),
    .b1     (b1),
    .out_vld(out_vld),
    .p00    (p00),
    .p01    (p01),
    .p10    (p10),
    .p11    (p11),
    .prod_s1(prod_s1)
);

// File: tb/test_pmul_array.sv
module test_pmul_array;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              in_vld;
    logic signed [3:0] a0, a1, b0, b1;
    logic              out_vld;
    logic signed [7:0] p00, p01, p10, p11;

    pmul_array i_pmul_array (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_vld),
        .a0     (a0),
        .a1     (a1),
        .b0     (b0),
        .b1     (b1),
        .out_vld(out_vld),
        .p00    (p00),
        .p01    (p01),
        .p10    (p10),
        .p11    (p11)
    );

    typedef struct {
        bit v;
        int e[4];
    } item_t;

    item_t q[$];
    bit    m_v;
    int    m_p[4];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output with the reference state; lanes are a0b0, a0b1, a1b0, a1b1.
    task automatic compare();
        string tags[4] = '{"R2", "R3", "R4", "R5"};
        int    act[4];
        act[0] = int'(p00);
        act[1] = int'(p01);
        act[2] = int'(p10);
        act[3] = int'(p11);
        chk("R1 out_vld", int'(out_vld), int'(m_v));
        for (int k = 0; k < 4; k++) begin
            string t;
            if (!m_v)                                t = {"R7/", tags[k]};
            else if (m_p[k] == 64 || m_p[k] == -56)  t = {tags[k], "/R6"};
            else                                     t = tags[k];
            chk(t, act[k], m_p[k]);
        end
    endtask

    // One cycle: check the outputs, then drive the next operand set.
    task automatic step(input bit v, input int x0, input int x1, input int y0, input int y1);
        item_t it;
        @(negedge clk);
        if (q.size() == 2) begin
            it  = q.pop_front();
            m_v = it.v;
            if (it.v) m_p = it.e;
        end
        compare();
        in_vld = v;
        a0 = 4'(x0);
        a1 = 4'(x1);
        b0 = 4'(y0);
        b1 = 4'(y1);
        it.v = v;
        it.e[0] = x0 * y0;
        it.e[1] = x0 * y1;
        it.e[2] = x1 * y0;
        it.e[3] = x1 * y1;
        q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        in_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 out_vld", int'(out_vld), 0);
        chk("R8 p00", int'(p00), 0);
        chk("R8 p01", int'(p01), 0);
        chk("R8 p10", int'(p10), 0);
        chk("R8 p11", int'(p11), 0);
        rst = 1'b0;
        q.delete();
        m_v = 1'b0;
        m_p = '{0, 0, 0, 0};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_vld = 1'b0;
        a0 = '0; a1 = '0; b0 = '0; b1 = '0;
        do_reset();

        // R6 extremes in every lane
        step(1, -8, -8, -8, -8);
        step(1, -8, 7, -8, 7);
        step(1, 7, -8, 7, -8);
        // R4: zero lane above a negative lane still needs the borrow
        step(1, -1, 3, 1, 0);
        step(1, 1, -2, -1, 0);
        // R7: garbage with in_vld low must not reach the outputs
        step(0, 5, -3, 2, 7);
        step(0, -8, -8, 7, 7);
        step(0, 1, 1, 1, 1);

        // Exhaustive sweep, R2..R5, with idle gaps for R7
        for (int i = 0; i < 65536; i++) begin
            step(1, ((i >> 12) & 15) - 8, ((i >> 8) & 15) - 8,
                    ((i >> 4) & 15) - 8, (i & 15) - 8);
            if (i % 97 == 3) step(0, i & 7, -(i & 7), 3, -4);
        end

        // R8: reset with sets in flight
        step(1, 7, 7, 7, 7);
        step(1, -8, 3, 2, -5);
        do_reset();
        step(1, 2, -3, 4, -5);
        repeat (4) step(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule